// File: doc/BRIEF.md
# Tuning Register Select Control

This block sits behind the serial command decoder of a direct digital synthesis core and turns the control-class 16-bit command words into register-selection and power state. It holds the mode bits that choose whether the active frequency register (one of two) and the active phase register (one of four) come from three external select pins or from select bits programmed by command. It also holds a sleep level and an accumulator-reset level, and it issues a one-cycle clear pulse that puts the block back into pin control with synchronization off.

When synchronization is enabled, both the programmed select bits and the external pins pass through a two-stage register pipeline before they reach the select outputs. This keeps a select change from landing while the source is still settling, at the cost of two extra clock cycles of latency. With synchronization off, pin changes reach the outputs combinationally and programmed bits take effect on the clock edge that accepts the command.

Commands arrive as a word plus a one-cycle valid strobe. The block has no back-pressure: it accepts a word on every clock edge where `cmd_valid` is high. Words whose 4-bit opcode (bits 15:12) belongs to the data-load class, or to the reserved test code, are ignored here.

Top module: `tune_sel_ctrl`

## Requirements
- R1: After reset, sync enable, pin/bit source select, sleep, accumulator reset, the clear pulse and all programmed select bits are 0, so the select outputs follow the pins.
- R2: A word with bits 15:14 = 2'b10 loads sync enable from bit 13 and the source select from bit 12; `sync_en` shows the sync level.
- R3: With the source select at 1, `freq_sel` and `phase_sel` come from the programmed bits: frequency bit from word bit 11, phase pair from word bits 10:9.
- R4: With the source select at 0 and sync off, `freq_sel` equals `pin_fsel` and `phase_sel` equals `pin_psel` in the same cycle.
- R5: Opcode 4'b0110 writes the frequency bit and both phase bits in one command.
- R6: Opcode 4'b0100 writes only the phase pair; opcode 4'b0101 writes only the frequency bit; the other field is kept.
- R7: With sync on, a change of programmed bits or of pins reaches the outputs after the second clock edge following the change, not after the first.
- R8: A word with bits 15:14 = 2'b11 loads `sleep` from bit 13 and `acc_reset` from bit 12; both are levels that stay until a later such word.
- R9: A power word with bit 11 = 1 clears sync enable and source select, pulses `clr_pulse` high for exactly one cycle, and leaves the programmed select bits unchanged.
- R10: Opcodes 4'b0111 and 4'b0000 to 4'b0011, and any word without `cmd_valid`, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word strobe, one word per high cycle |
| cmd_word | input | 16 | Decoded command word |
| pin_fsel | input | 1 | External frequency register select pin |
| pin_psel | input | 2 | External phase register select pins |
| freq_sel | output | 1 | Effective frequency register select |
| phase_sel | output | 2 | Effective phase register select |
| sync_en | output | 1 | Synchronization enabled |
| sleep | output | 1 | Sleep level |
| acc_reset | output | 1 | Phase accumulator held at zero |
| clr_pulse | output | 1 | One-cycle clear indication |

## Verification
The assertions assume the pins and command inputs are steady around each rising edge and that a command strobe lasts one cycle per word. The bench drives every input on the falling edge and samples outputs just after it, and it moves the pins only while the command strobe is low. Each latency check counts edges from the accepting edge, with the bits and pins held steady for at least two edges before a synchronized change so the pipeline holds known values.

// File: rtl/tune_sel_pkg.sv
package tune_sel_pkg;
  localparam int CMD_W = 16;
  localparam int OP_W  = 4;

  typedef enum logic [OP_W-1:0] {
    OP_PHASE_ONLY = 4'b0100,
    OP_FREQ_ONLY  = 4'b0101,
    OP_BOTH       = 4'b0110,
    OP_TEST       = 4'b0111
  } sel_op_e;

  typedef struct packed {
    logic       fsel;
    logic [1:0] psel;
  } sel_t;

  localparam int SEL_W = $bits(sel_t);
endpackage

// File: rtl/tune_sel_decode.sv
module tune_sel_decode
  import tune_sel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_word,
  output logic             sync_o,
  output logic             srcbits_o,
  output logic             sleep_o,
  output logic             accrst_o,
  output logic             clr_o,
  output sel_t             bits_o
);
  localparam int CLS_HI = CMD_W - 1;
  localparam int CLS_LO = CMD_W - 2;

  logic [OP_W-1:0] op;
  logic            is_mode, is_power, clr_req;

  assign op       = cmd_word[CMD_W-1 -: OP_W];
  assign is_mode  = cmd_valid && cmd_word[CLS_HI:CLS_LO] == 2'b10;
  assign is_power = cmd_valid && cmd_word[CLS_HI:CLS_LO] == 2'b11;
  assign clr_req  = is_power && cmd_word[11];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_o    <= 1'b0;
      srcbits_o <= 1'b0;
      sleep_o   <= 1'b0;
      accrst_o  <= 1'b0;
      clr_o     <= 1'b0;
      bits_o    <= '0;
    end else begin
      clr_o <= clr_req;
      if (is_mode) begin
        sync_o    <= cmd_word[13];
        srcbits_o <= cmd_word[12];
      end
      if (is_power) begin
        sleep_o  <= cmd_word[13];
        accrst_o <= cmd_word[12];
        if (cmd_word[11]) begin
          sync_o    <= 1'b0;
          srcbits_o <= 1'b0;
        end
      end
      if (cmd_valid) begin
        case (op)
          OP_PHASE_ONLY: bits_o.psel <= cmd_word[10:9];
          OP_FREQ_ONLY:  bits_o.fsel <= cmd_word[11];
          OP_BOTH: begin
            bits_o.psel <= cmd_word[10:9];
            bits_o.fsel <= cmd_word[11];
          end
          default: ;
        endcase
      end
    end
  end

  assert_clr_drops_modes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> (!sync_o && !srcbits_o && clr_o));

  assert_clr_selfclear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_o && !clr_req) |=> !clr_o);

  assert_test_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == OP_TEST) |=>
      $stable({sync_o, srcbits_o, sleep_o, accrst_o, bits_o}));

  assert_power_levels_R8: assert property (@(posedge clk) disable iff (!rst_n)
    is_power |=> (sleep_o == $past(cmd_word[13]) && accrst_o == $past(cmd_word[12])));
endmodule

// File: rtl/tune_sel_delay.sv
module tune_sel_delay #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q = d;
    end else begin : g_chain
      logic [WIDTH-1:0] stage [STAGES];
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
          if (!rst_n) stage[i] <= '0;
          else if (i == 0) stage[i] <= d;
          else stage[i] <= stage[(i == 0) ? 0 : i-1];
        end
      end
      assign q = stage[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/tune_sel_ctrl.sv
module tune_sel_ctrl
  import tune_sel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [15:0] cmd_word,
  input  logic        pin_fsel,
  input  logic [1:0]  pin_psel,
  output logic        freq_sel,
  output logic [1:0]  phase_sel,
  output logic        sync_en,
  output logic        sleep,
  output logic        acc_reset,
  output logic        clr_pulse
);
  logic srcbits;
  sel_t bits_now, bits_dly, pins_now, pins_dly, bits_eff, pins_eff, chosen;

  tune_sel_decode u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .sync_o    (sync_en),
    .srcbits_o (srcbits),
    .sleep_o   (sleep),
    .accrst_o  (acc_reset),
    .clr_o     (clr_pulse),
    .bits_o    (bits_now)
  );

  assign pins_now = '{fsel: pin_fsel, psel: pin_psel};

  tune_sel_delay #(.WIDTH(SEL_W), .STAGES(SYNC_STAGES)) u_bits_dly (
    .clk (clk), .rst_n (rst_n), .d (bits_now), .q (bits_dly)
  );

  tune_sel_delay #(.WIDTH(SEL_W), .STAGES(SYNC_STAGES)) u_pins_dly (
    .clk (clk), .rst_n (rst_n), .d (pins_now), .q (pins_dly)
  );

  assign bits_eff  = sync_en ? bits_dly : bits_now;
  assign pins_eff  = sync_en ? pins_dly : pins_now;
  assign chosen    = srcbits ? bits_eff : pins_eff;
  assign freq_sel  = chosen.fsel;
  assign phase_sel = chosen.psel;

  assert_pins_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!srcbits && !sync_en) |-> (freq_sel == pin_fsel && phase_sel == pin_psel));

  generate
    if (SYNC_STAGES == 2) begin : g_sync_chk
      assert_pins_two_edges_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!srcbits && sync_en && $past(sync_en)) |->
          (phase_sel == $past(pin_psel, 2) && freq_sel == $past(pin_fsel, 2)));
    end
  endgenerate
endmodule

// File: tb/tune_sel_ctrl_test.sv
`timescale 1ns/1ps
module tune_sel_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic        pin_fsel = 1'b0;
  logic [1:0]  pin_psel = 2'b00;
  logic        freq_sel, sync_en, sleep, acc_reset, clr_pulse;
  logic [1:0]  phase_sel;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  tune_sel_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .pin_fsel(pin_fsel), .pin_psel(pin_psel), .freq_sel(freq_sel),
    .phase_sel(phase_sel), .sync_en(sync_en), .sleep(sleep),
    .acc_reset(acc_reset), .clr_pulse(clr_pulse)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_sel(input string tag, input logic f, input logic [1:0] p);
    chk(tag, {1'b0, freq_sel, phase_sel}, {1'b0, f, p});
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_word = w;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0; cmd_word = '0;
    #1;
  endtask

  function automatic logic [15:0] sel_word(input logic [3:0] op, input logic f, input logic [1:0] p);
    return {op, f, p, 9'd0};
  endfunction

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    // R1: reset state
    chk("R1 levels", {sync_en, sleep, acc_reset, clr_pulse}, 4'b0000);
    pin_fsel = 1'b1; pin_psel = 2'b01; #1;
    chk_sel("R1 follows pins", 1'b1, 2'b01);

    // R4: pin sweep, combinational
    for (int v = 0; v < 8; v++) begin
      @(negedge clk); pin_fsel = v[2]; pin_psel = v[1:0]; #1;
      chk_sel("R4 pin sweep", v[2], v[1:0]);
    end

    // R2/R3/R5: bits source, all combinations via combined opcode
    send(16'h9000);
    chk("R2 sync off", {3'b0, sync_en}, 4'h0);
    for (int v = 0; v < 8; v++) begin
      @(negedge clk); pin_fsel = ~v[2]; pin_psel = ~v[1:0];
      send(sel_word(4'b0110, v[2], v[1:0]));
      chk_sel("R3 R5 combined sweep", v[2], v[1:0]);
    end
    // now f=1 p=3
    send(sel_word(4'b0100, 1'b0, 2'b01));
    chk_sel("R6 phase only", 1'b1, 2'b01);
    send(sel_word(4'b0101, 1'b0, 2'b10));
    chk_sel("R6 freq only", 1'b0, 2'b01);
    send(sel_word(4'b0100, 1'b1, 2'b10));
    chk_sel("R6 phase only keeps freq", 1'b0, 2'b10);

    // R10: ignored codes
    send(16'h7FFF);
    chk_sel("R10 test code", 1'b0, 2'b10);
    chk("R10 test code levels", {sync_en, sleep, acc_reset, clr_pulse}, 4'b0000);
    for (int c = 0; c < 4; c++) begin
      send({c[3:0], 12'hFFF});
      chk_sel("R10 data codes", 1'b0, 2'b10);
    end
    @(negedge clk); cmd_word = 16'hE800; #1; step();
    chk("R10 no strobe", {sync_en, sleep, acc_reset, clr_pulse}, 4'b0000);
    cmd_word = '0;

    // R7: sync on, bits path
    send(16'hB000);
    chk("R2 sync on", {3'b0, sync_en}, 4'h1);
    step(); step();
    send(sel_word(4'b0110, 1'b1, 2'b11));
    chk_sel("R7 bits after 0 edges", 1'b0, 2'b10);
    step();
    chk_sel("R7 bits after 1 edge", 1'b0, 2'b10);
    step();
    chk_sel("R7 bits after 2 edges", 1'b1, 2'b11);

    // R7: sync on, pins path
    @(negedge clk); pin_fsel = 1'b0; pin_psel = 2'b00;
    send(16'hA000);
    step(); step();
    chk_sel("R7 pins settled", 1'b0, 2'b00);
    @(negedge clk); pin_fsel = 1'b1; pin_psel = 2'b10; #1;
    chk_sel("R7 pins after 0 edges", 1'b0, 2'b00);
    step();
    chk_sel("R7 pins after 1 edge", 1'b0, 2'b00);
    step();
    chk_sel("R7 pins after 2 edges", 1'b1, 2'b10);

    // R8: power levels
    send(16'hE000);
    chk("R8 sleep only", {2'b0, sleep, acc_reset}, 4'b0010);
    step(); step();
    chk("R8 levels held", {2'b0, sleep, acc_reset}, 4'b0010);
    send(16'hD000);
    chk("R8 reset only", {2'b0, sleep, acc_reset}, 4'b0001);
    send(16'hF000);
    chk("R8 both", {2'b0, sleep, acc_reset}, 4'b0011);
    send(16'hC000);
    chk("R8 both off", {2'b0, sleep, acc_reset}, 4'b0000);
    chk("R8 power keeps sync", {3'b0, sync_en}, 4'h1);

    // R9: clear
    send(16'hB000); step(); step();
    @(negedge clk); pin_fsel = 1'b0; pin_psel = 2'b01; #1;
    send(16'hE800);
    chk("R9 clear effect", {sync_en, sleep, acc_reset, clr_pulse}, 4'b0101);
    chk_sel("R9 back to pins", 1'b0, 2'b01);
    step();
    chk("R9 pulse ends", {3'b0, clr_pulse}, 4'h0);
    send(16'h9000);
    chk_sel("R9 bits kept", 1'b1, 2'b11);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule